// File: doc/BRIEF.md
# Priority-Chain Bus Responder

This block is the response logic of one device controller sitting on a shared I/O processor bus. Controllers are wired in a ripple chain. Each one receives an availability signal from its higher-priority neighbour and forwards availability to its lower-priority neighbour. The block holds two request latches, one for service calls and one for interrupt calls. Each pending request can be marked urgent, and an urgent request drives a bus-wide high-priority line for its kind.

When the bus raises its function strobe together with one of six function indicators, the block waits for availability from upstream. It then either claims the cycle, raising strobe-acknowledge and driving the response lines, or passes availability downstream. For the two acknowledge indicators it claims only when the matching request is pending and no other controller holds the matching high-priority line. For the four command indicators it claims when it is addressed and connected. While claiming an acknowledge cycle it drives its own device address on the response lines. While claiming a command cycle it drives the status input.

The sequencer has five named states:
- IDLE waits for a strobe.
- WAIT_AVAIL holds a valid strobe until availability arrives.
- CLAIM drives the acknowledge.
- PASS drives availability-out.
- IGNORE absorbs a malformed strobe.

Its transitions are:
- IDLE goes to WAIT_AVAIL on a valid strobe, or to IGNORE on a malformed one.
- WAIT_AVAIL goes to CLAIM or PASS when availability-in is seen true, or back to IDLE when the strobe falls.
- CLAIM, PASS and IGNORE each return to IDLE when the strobe falls.

Top module: `chain_responder`

## Requirements
- R1: A one-cycle pulse on `irq_req_i` (or `svc_req_i`) makes `irq_call_o` (or `svc_call_o`) high from the next cycle. It stays high until that request is cleared by R10. A reset clears both.
- R2: `hp_irq_o` (or `hp_svc_o`) is high exactly while the pending request of that kind was set with `irq_hi_i` (or `svc_hi_i`) high in its set cycle.
- R3: While `avail_in` stays low during a strobe, `ack_o` and `avail_out_o` both stay low.
- R4: The indicator encoding on `fn_i` is bit 0 start, bit 1 halt, bit 2 test-I/O, bit 3 test-device, bit 4 acknowledge-interrupt and bit 5 acknowledge-service. With a valid strobe and `avail_in` high, the decision appears two cycles after the strobe is first sampled. It appears one cycle after `avail_in` is first sampled high if that comes later. With no matching request pending, the decision is `avail_out_o`.
- R5: On acknowledge-interrupt with an interrupt pending, the block claims (`ack_o`) if `hp_irq_in` is low or this block drives `hp_irq_o`. Otherwise it raises `avail_out_o`.
- R6: On acknowledge-service with a service call pending, the same rule as R5 applies using `hp_svc_in` and `hp_svc_o`.
- R7: While claiming an acknowledge-interrupt or acknowledge-service cycle, `resp_o` equals the parameter `DEV_ADDR`.
- R8: On a command indicator (bits 0 to 3), the block claims only if `sel_addr_i` equals `DEV_ADDR` and `connected_i` is high, and then drives `resp_o` equal to `status_i`. Otherwise it raises `avail_out_o`.
- R9: A strobe with zero or more than one bit of `fn_i` set causes no `ack_o` or `avail_out_o` and leaves the pending requests unchanged.
- R10: One cycle after `strobe_i` is sampled low, `ack_o` and `avail_out_o` are low. If this block had acknowledged an acknowledge-interrupt or acknowledge-service cycle, that pending request is clear in the same cycle.
- R11: `ack_o` and `avail_out_o` are never high together, and `resp_o` is zero whenever `ack_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 1 | Pulse: post an interrupt request |
| irq_hi_i | input | 1 | Mark the posted interrupt urgent |
| svc_req_i | input | 1 | Pulse: post a service request |
| svc_hi_i | input | 1 | Mark the posted service request urgent |
| avail_in | input | 1 | Availability from the higher-priority neighbour |
| hp_irq_in | input | 1 | Bus state of the urgent-interrupt line |
| hp_svc_in | input | 1 | Bus state of the urgent-service line |
| strobe_i | input | 1 | Function strobe |
| fn_i | input | 6 | Function indicators, one-hot |
| sel_addr_i | input | ADDR_W | Address sent with command indicators |
| connected_i | input | 1 | Controller is connected to its device |
| status_i | input | RESP_W | Status for command responses |
| irq_call_o | output | 1 | Interrupt call pending |
| svc_call_o | output | 1 | Service call pending |
| hp_irq_o | output | 1 | Drives the urgent-interrupt line |
| hp_svc_o | output | 1 | Drives the urgent-service line |
| ack_o | output | 1 | Strobe acknowledge |
| avail_out_o | output | 1 | Availability to the lower-priority neighbour |
| resp_o | output | RESP_W | Function-response lines |

## Verification
A sequencer stuck in the wrong state shows as a missing or doubled chain output. A claim shows without a pass, or the reverse, or either output persists past the cycle after the strobe falls, so it is visible within two cycles of any strobe edge. A wrong request latch shows on `irq_call_o`, `svc_call_o` and the urgent-line outputs the cycle after a post or a claimed cycle. It also shows later as a pass where a claim was due. A wrong decision input appears as the wrong one of `ack_o` and `avail_out_o`, or as wrong `resp_o` contents, in the first cycle of the decision.

// File: rtl/chain_pkg.sv
package chain_pkg;
    localparam int FN_W      = 6;
    localparam int FN_START  = 0;
    localparam int FN_HALT   = 1;
    localparam int FN_TESTIO = 2;
    localparam int FN_TESTDV = 3;
    localparam int FN_ACKINT = 4;
    localparam int FN_ACKSVC = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_AVAIL,
        ST_CLAIM,
        ST_PASS,
        ST_IGNORE
    } seq_state_t;
endpackage

// File: rtl/chain_req_latch.sv
module chain_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic hi_i,
    input  logic clr_i,
    output logic pend_o,
    output logic hi_o
);
    logic pend_q;
    logic hi_q;

    // A new post wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            hi_q   <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
            hi_q   <= hi_i;
        end else if (clr_i) begin
            pend_q <= 1'b0;
            hi_q   <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign hi_o   = pend_q & hi_q;

    p_hi_implies_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_o |-> pend_o);
    p_set_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);
endmodule

// File: rtl/chain_claim_eval.sv
module chain_claim_eval
    import chain_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
    input  logic [FN_W-1:0]   fn_i,
    input  logic              irq_pend_i,
    input  logic              irq_mine_hp_i,
    input  logic              hp_irq_in,
    input  logic              svc_pend_i,
    input  logic              svc_mine_hp_i,
    input  logic              hp_svc_in,
    input  logic [ADDR_W-1:0] sel_addr_i,
    input  logic              connected_i,
    output logic              claim_o,
    output logic              is_ack_kind_o
);
    logic cmd_kind;
    logic int_ok;
    logic svc_ok;
    logic cmd_ok;

    assign cmd_kind      = |fn_i[FN_TESTDV:FN_START];
    assign is_ack_kind_o = fn_i[FN_ACKINT] | fn_i[FN_ACKSVC];

    assign int_ok = fn_i[FN_ACKINT] & irq_pend_i & (~hp_irq_in | irq_mine_hp_i);
    assign svc_ok = fn_i[FN_ACKSVC] & svc_pend_i & (~hp_svc_in | svc_mine_hp_i);
    assign cmd_ok = cmd_kind & (sel_addr_i == DEV_ADDR) & connected_i;

    assign claim_o = int_ok | svc_ok | cmd_ok;
endmodule

// File: rtl/chain_responder.sv
module chain_responder
    import chain_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int RESP_W = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req_i,
    input  logic              irq_hi_i,
    input  logic              svc_req_i,
    input  logic              svc_hi_i,
    input  logic              avail_in,
    input  logic              hp_irq_in,
    input  logic              hp_svc_in,
    input  logic              strobe_i,
    input  logic [FN_W-1:0]   fn_i,
    input  logic [ADDR_W-1:0] sel_addr_i,
    input  logic              connected_i,
    input  logic [RESP_W-1:0] status_i,
    output logic              irq_call_o,
    output logic              svc_call_o,
    output logic              hp_irq_o,
    output logic              hp_svc_o,
    output logic              ack_o,
    output logic              avail_out_o,
    output logic [RESP_W-1:0] resp_o
);
    localparam logic [RESP_W-1:0] ADDR_RESP = RESP_W'(DEV_ADDR);

    seq_state_t      state_q, state_d;
    logic [FN_W-1:0] fn_q;
    logic            fn_valid;
    logic            claim;
    logic            ack_kind;
    logic            clr_irq;
    logic            clr_svc;
    logic            leave_claim;

    assign fn_valid    = ($countones(fn_i) == 1);
    assign leave_claim = (state_q == ST_CLAIM) && !strobe_i;
    assign clr_irq     = leave_claim && fn_q[FN_ACKINT];
    assign clr_svc     = leave_claim && fn_q[FN_ACKSVC];

    chain_req_latch u_irq_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_req_i),
        .hi_i   (irq_hi_i),
        .clr_i  (clr_irq),
        .pend_o (irq_call_o),
        .hi_o   (hp_irq_o)
    );

    chain_req_latch u_svc_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (svc_req_i),
        .hi_i   (svc_hi_i),
        .clr_i  (clr_svc),
        .pend_o (svc_call_o),
        .hi_o   (hp_svc_o)
    );

    chain_claim_eval #(
        .ADDR_W   (ADDR_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_eval (
        .fn_i          (fn_q),
        .irq_pend_i    (irq_call_o),
        .irq_mine_hp_i (hp_irq_o),
        .hp_irq_in     (hp_irq_in),
        .svc_pend_i    (svc_call_o),
        .svc_mine_hp_i (hp_svc_o),
        .hp_svc_in     (hp_svc_in),
        .sel_addr_i    (sel_addr_i),
        .connected_i   (connected_i),
        .claim_o       (claim),
        .is_ack_kind_o (ack_kind)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe_i) state_d = fn_valid ? ST_WAIT_AVAIL : ST_IGNORE;
            end
            ST_WAIT_AVAIL: begin
                if (!strobe_i)     state_d = ST_IDLE;
                else if (avail_in) state_d = claim ? ST_CLAIM : ST_PASS;
            end
            ST_CLAIM,
            ST_PASS,
            ST_IGNORE: begin
                if (!strobe_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and latched indicator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fn_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && strobe_i && fn_valid) fn_q <= fn_i;
        end
    end

    // Outputs
    always_comb begin
        ack_o       = 1'b0;
        avail_out_o = 1'b0;
        resp_o      = '0;
        unique case (state_q)
            ST_CLAIM: begin
                ack_o  = 1'b1;
                resp_o = ack_kind ? ADDR_RESP : status_i;
            end
            ST_PASS:  avail_out_o = 1'b1;
            ST_IDLE,
            ST_WAIT_AVAIL,
            ST_IGNORE: ;
            default: ;
        endcase
    end

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_o && avail_out_o));
    p_quiet_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> (resp_o == '0));
    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> (!ack_o && !avail_out_o));
    p_need_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_AVAIL && !avail_in) |=> (!ack_o && !avail_out_o));
    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && strobe_i && $countones(fn_i) != 1)
            |=> (!ack_o && !avail_out_o));
    p_clear_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !strobe_i && fn_q[FN_ACKINT] && !irq_req_i) |=> !irq_call_o);
    p_claim_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && (fn_q[FN_ACKINT] || fn_q[FN_ACKSVC])) |-> (resp_o == ADDR_RESP));
endmodule

// File: tb/chain_responder_bench.sv
module chain_responder_bench;
    localparam logic [7:0] MY_ADDR = 8'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_req_i = 0, irq_hi_i = 0, svc_req_i = 0, svc_hi_i = 0;
    logic       avail_in = 0, hp_irq_in = 0, hp_svc_in = 0, strobe_i = 0;
    logic [5:0] fn_i = '0;
    logic [7:0] sel_addr_i = '0;
    logic       connected_i = 0;
    logic [7:0] status_i = '0;
    logic       irq_call_o, svc_call_o, hp_irq_o, hp_svc_o, ack_o, avail_out_o;
    logic [7:0] resp_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    chain_responder #(.ADDR_W(8), .RESP_W(8), .DEV_ADDR(MY_ADDR)) u_chain_responder (
        .clk(clk), .rst_n(rst_n),
        .irq_req_i(irq_req_i), .irq_hi_i(irq_hi_i),
        .svc_req_i(svc_req_i), .svc_hi_i(svc_hi_i),
        .avail_in(avail_in), .hp_irq_in(hp_irq_in), .hp_svc_in(hp_svc_in),
        .strobe_i(strobe_i), .fn_i(fn_i), .sel_addr_i(sel_addr_i),
        .connected_i(connected_i), .status_i(status_i),
        .irq_call_o(irq_call_o), .svc_call_o(svc_call_o),
        .hp_irq_o(hp_irq_o), .hp_svc_o(hp_svc_o),
        .ack_o(ack_o), .avail_out_o(avail_out_o), .resp_o(resp_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Checks ack/avail_out pair and response lines together.
    task automatic check_chain(input string req, input logic exp_ack,
                               input logic exp_avo, input logic [7:0] exp_resp);
        check({req, " ack"}, ack_o, exp_ack);
        check({req, " avail_out"}, avail_out_o, exp_avo);
        check({req, " resp"}, resp_o, exp_resp);
        check("R11 exclusive", ack_o & avail_out_o, 1'b0);
    endtask

    task automatic post_irq(input logic hi);
        @(negedge clk); irq_req_i = 1; irq_hi_i = hi;
        @(negedge clk); irq_req_i = 0; irq_hi_i = 0;
    endtask

    task automatic post_svc(input logic hi);
        @(negedge clk); svc_req_i = 1; svc_hi_i = hi;
        @(negedge clk); svc_req_i = 0; svc_hi_i = 0;
    endtask

    // Raise strobe with avail_in high, wait two cycles to the decision.
    task automatic strobe_up(input logic [5:0] fn);
        @(negedge clk); strobe_i = 1; fn_i = fn; avail_in = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_down(input string req);
        strobe_i = 0; fn_i = '0; avail_in = 0;
        @(negedge clk);
        check_chain(req, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_reset;
        check("R1 reset irq", irq_call_o, 0);
        check("R1 reset svc", svc_call_o, 0);
        check("R2 reset hp", {hp_irq_o, hp_svc_o}, 0);
        check_chain("R11 reset", 0, 0, 8'h00);
    endtask

    task automatic t_no_request;
        strobe_up(6'b010000);
        check_chain("R4 no irq pending", 0, 1, 8'h00);
        strobe_down("R10 drop after pass");
        strobe_up(6'b100000);
        check_chain("R4 no svc pending", 0, 1, 8'h00);
        strobe_down("R10 drop after pass svc");
    endtask

    task automatic t_latch;
        post_irq(0);
        check("R1 irq set", irq_call_o, 1);
        check("R2 irq not urgent", hp_irq_o, 0);
        post_svc(1);
        check("R1 svc set", svc_call_o, 1);
        check("R2 svc urgent", hp_svc_o, 1);
    endtask

    task automatic t_wait_avail;
        @(negedge clk); strobe_i = 1; fn_i = 6'b010000; avail_in = 0;
        repeat (4) @(negedge clk);
        check_chain("R3 no avail", 0, 0, 8'h00);
        avail_in = 1;
        @(negedge clk);
        check_chain("R5 claim int", 1, 0, MY_ADDR);
        check("R7 addr on int claim", resp_o, MY_ADDR);
        strobe_down("R10 drop after claim");
        check("R10 irq cleared", irq_call_o, 0);
        check("R10 svc untouched", svc_call_o, 1);
    endtask

    task automatic t_hp_irq;
        post_irq(0);
        hp_irq_in = 1;
        strobe_up(6'b010000);
        check_chain("R5 blocked by other urgent", 0, 1, 8'h00);
        strobe_down("R10 drop");
        check("R5 irq kept after pass", irq_call_o, 1);
        post_irq(1);
        check("R2 irq urgent", hp_irq_o, 1);
        strobe_up(6'b010000);
        check_chain("R5 own urgent claims", 1, 0, MY_ADDR);
        strobe_down("R10 drop");
        check("R10 irq cleared urgent", {irq_call_o, hp_irq_o}, 2'b00);
        hp_irq_in = 0;
    endtask

    task automatic t_svc;
        // svc pending urgent from t_latch; line shows our own drive
        post_svc(0);
        hp_svc_in = 1;
        strobe_up(6'b100000);
        check_chain("R6 blocked by other urgent", 0, 1, 8'h00);
        strobe_down("R10 drop");
        post_svc(1);
        strobe_up(6'b100000);
        check_chain("R6 own urgent claims", 1, 0, MY_ADDR);
        strobe_down("R10 drop");
        check("R10 svc cleared", svc_call_o, 0);
        hp_svc_in = 0;
        post_svc(0);
        strobe_up(6'b100000);
        check_chain("R6 plain claim", 1, 0, MY_ADDR);
        strobe_down("R10 drop");
    endtask

    task automatic t_commands;
        sel_addr_i = MY_ADDR; connected_i = 1; status_i = 8'h5C;
        strobe_up(6'b000001);
        check_chain("R8 start addressed", 1, 0, 8'h5C);
        strobe_down("R10 drop");
        status_i = 8'hC3;
        strobe_up(6'b000100);
        check_chain("R8 test-io addressed", 1, 0, 8'hC3);
        strobe_down("R10 drop");
        connected_i = 0;
        strobe_up(6'b000010);
        check_chain("R8 halt not connected", 0, 1, 8'h00);
        strobe_down("R10 drop");
        connected_i = 1; sel_addr_i = 8'h11;
        strobe_up(6'b001000);
        check_chain("R8 test-dev other addr", 0, 1, 8'h00);
        strobe_down("R10 drop");
    endtask

    task automatic t_protocol_error;
        post_irq(0);
        strobe_up(6'b000000);
        check_chain("R9 no indicator", 0, 0, 8'h00);
        strobe_down("R10 drop");
        sel_addr_i = MY_ADDR;
        strobe_up(6'b010001);
        @(negedge clk);
        check_chain("R9 two indicators", 0, 0, 8'h00);
        strobe_down("R10 drop");
        check("R9 irq still pending", irq_call_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_no_request();
        t_latch();
        t_wait_avail();
        t_hp_irq();
        t_svc();
        t_commands();
        t_protocol_error();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule